// File: doc/BRIEF.md
# Return-from-Exception Sequencer

This block performs the privileged return from an exception or interrupt handler. When `start` is pulsed, it reads two longwords from the current stack through a read port. The first longword is the saved program counter and the second is the saved status word. It then checks the popped status word against the live status register, using a set of privilege, priority-level, stack-selection and compatibility rules.

If the word is legal, the block saves the outgoing stack pointer into a five-slot bank: four per-mode slots and one interrupt-stack slot. It then selects a new stack pointer from that bank and loads the PC and the status register in one cycle. If the word is illegal, or a stack read reports an access error, nothing in the architectural state changes and a one-cycle fault is reported together with `done`.

The stack read port is a valid/ready request channel with a separate response strobe. The request holds its address steady until `mem_req_ready` is seen. The block waits for any number of cycles between acceptance and `mem_rsp_valid`. It accepts exactly one response per accepted request and has no ready signal of its own on responses. `init_en` loads the status register and the stack pointer while the block is idle, and takes priority over `start` in the same cycle.

Top module: `rfe_seq`

## Requirements
- R1: The first request reads address SP and the second reads SP+4. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held.
- R2: A reserved-operand fault is raised when any of these holds for the popped word: its current mode (bits 25:24) is below the live current mode; its previous mode (bits 23:22) is below the live current mode; its priority level (bits 20:16) is above the live level; or any must-be-zero bit (29:28, 21, 15:8) is set.
- R3: A popped word with the interrupt-stack bit (26) set faults if the live bit 26 is 0, if its current mode is not 0, or if its priority level is 0.
- R4: A popped word with a nonzero priority level and a current mode other than 0 faults.
- R5: A popped word with the compatibility bit (31) set faults if any of bits 27, 26, 7, 6, 5 is set, or if its current mode is not 3.
- R6: On a reserved-operand fault, PC, status register, SP and all bank slots keep their values. `rsvd_fault` and `done` are high for exactly one cycle.
- R7: On success, SP+8 (the pointer after both pops) is written to bank slot 4 if the live bit 26 is 1, else to the slot numbered by the live current mode.
- R8: On success, the new SP is the bank slot selected by the popped word: slot 4 if its bit 26 is set, else its current mode. This includes the value just written in the same step.
- R9: If the live trace-pending bit (30) is 1, bit 30 of the loaded status word is forced to 1.
- R10: On success, PC takes the first popped longword and the status register takes the second. Condition codes N,Z,V,C come from its bits 3..0. The status register changes only on success or `init_en`.
- R11: If either response has `mem_rsp_err` set, `stk_fault` and `done` pulse for one cycle, no further request is issued, and PC, status register, SP and bank are unchanged.
- R12: After reset, the status register is 0x041F0000, PC is 0, SP is `RESET_SP`, and bank slot i holds `SP_BASE + i*SLOT_GAP`. `init_en` loads status and SP when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| init_en | input | 1 | Load `init_psl` and `init_sp` while idle |
| init_psl | input | 32 | Status value to load |
| init_sp | input | 32 | Stack pointer value to load |
| start | input | 1 | Begin a return sequence (idle only) |
| busy | output | 1 | Sequence in progress |
| mem_req_valid | output | 1 | Stack read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Stack read address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Access error on this response |
| done | output | 1 | One-cycle completion pulse |
| rsvd_fault | output | 1 | Reserved-operand fault, with `done` |
| stk_fault | output | 1 | Stack access fault, with `done` |
| pc_o | output | 32 | Program counter |
| psl_o | output | 32 | Status register |
| sp_o | output | 32 | Current stack pointer |
| sp_bank_o | output | 160 | Bank slots, slot i at bits 32i+31:32i |

## Verification
The bench sweeps popped status words over all current/previous mode pairs, interrupt-stack and compatibility settings, three priority levels and rotating must-be-zero bits, against four live status words.

- A design that compares modes with the wrong sign, or that skips a rule, would accept a word that must fault. It would then load PC and change the stack pointer.
- A bank without same-step forwarding would return the stale slot when the save and restore slots coincide.
- Access errors injected on either pop catch a design that updates SP after a partial pop.
- Stalls of `mem_req_ready` catch an address that moves while it is held.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NMODES = 4;
  localparam logic [1:0] MODE_KERNEL = 2'd0;
  localparam logic [1:0] MODE_USER   = 2'd3;

  typedef struct packed {
    logic       cm;
    logic       tp;
    logic [1:0] mbz_hi;
    logic       fpd;
    logic       istk;
    logic [1:0] cur;
    logic [1:0] prv;
    logic       mbz_mid;
    logic [4:0] ipl;
    logic [7:0] mbz_lo;
    logic       dv;
    logic       fu;
    logic       iv;
    logic       t;
    logic [3:0] cc;
  } psl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_PC, ST_WAIT_PC, ST_REQ_PSL, ST_WAIT_PSL, ST_COMMIT
  } seq_st_t;
endpackage

// File: rtl/rfe_psl_check.sv
module rfe_psl_check
  import rfe_pkg::*;
(
  input  psl_t nxt,
  input  psl_t live,
  output logic illegal
);
  logic mode_bad, ipl_bad, mbz_bad, istk_bad, ipl_mode_bad, compat_bad;

  always_comb begin
    mode_bad     = (nxt.cur < live.cur) || (nxt.prv < live.cur);
    ipl_bad      = nxt.ipl > live.ipl;
    mbz_bad      = |{nxt.mbz_hi, nxt.mbz_mid, nxt.mbz_lo};
    istk_bad     = nxt.istk && (!live.istk || (nxt.cur != MODE_KERNEL) || (nxt.ipl == '0));
    ipl_mode_bad = (nxt.ipl != '0) && (nxt.cur != MODE_KERNEL);
    compat_bad   = nxt.cm && ((|{nxt.fpd, nxt.istk, nxt.dv, nxt.fu, nxt.iv}) ||
                              (nxt.cur != MODE_USER));
    illegal      = mode_bad | ipl_bad | mbz_bad | istk_bad | ipl_mode_bad | compat_bad;
  end
endmodule

// File: rtl/rfe_sp_bank.sv
module rfe_sp_bank #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NSLOT  = 5,
  parameter logic [DW-1:0] SP_BASE  = '0,
  parameter logic [DW-1:0] SLOT_GAP = '0,
  localparam int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic [SLOT_W-1:0]   rd_idx,
  output logic [DW-1:0]       rd_data,
  output logic [NSLOT*DW-1:0] bank_flat
);
  logic [DW-1:0] slot_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= SP_BASE + SLOT_GAP * DW'(g);
      else if (wr_en && wr_idx == SLOT_W'(g)) slot_q[g] <= wr_data;
    end
    assign bank_flat[g*DW +: DW] = slot_q[g];
  end

  // Read sees a write to the same slot in the same cycle.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++)
      if (rd_idx == SLOT_W'(i)) rd_data = slot_q[i];
    if (wr_en && wr_idx == rd_idx) rd_data = wr_data;
  end
endmodule

// File: rtl/rfe_seq.sv
module rfe_seq
  import rfe_pkg::*;
#(
  parameter logic [31:0] RESET_SP  = 32'h0000_F000,
  parameter logic [31:0] SP_BASE   = 32'h0001_0000,
  parameter logic [31:0] SLOT_GAP  = 32'h0000_1000,
  parameter logic [31:0] RESET_PSL = 32'h041F_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_en,
  input  logic [31:0]   init_psl,
  input  logic [31:0]   init_sp,
  input  logic          start,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          done,
  output logic          rsvd_fault,
  output logic          stk_fault,
  output logic [31:0]   pc_o,
  output logic [31:0]   psl_o,
  output logic [31:0]   sp_o,
  output logic [159:0]  sp_bank_o
);
  localparam int unsigned NSLOT   = NMODES + 1;
  localparam int unsigned SLOT_W  = $clog2(NSLOT);
  localparam int unsigned STEP    = WORD_W / 8;
  localparam logic [SLOT_W-1:0] IS_SLOT = SLOT_W'(NMODES);

  seq_st_t           st_q;
  psl_t              live_q, tmp_psl_q, loaded;
  logic [WORD_W-1:0] pc_q, sp_q, base_sp_q, tmp_pc_q, sp_after, new_sp;
  logic              illegal, commit_ok;
  logic [SLOT_W-1:0] save_idx, load_idx;

  rfe_psl_check u_check (.nxt(tmp_psl_q), .live(live_q), .illegal(illegal));

  assign commit_ok = (st_q == ST_COMMIT) && !illegal;
  assign sp_after  = base_sp_q + WORD_W'(2 * STEP);
  assign save_idx  = live_q.istk ? IS_SLOT : SLOT_W'(live_q.cur);
  assign load_idx  = tmp_psl_q.istk ? IS_SLOT : SLOT_W'(tmp_psl_q.cur);

  rfe_sp_bank #(
    .DW(WORD_W), .NSLOT(NSLOT), .SP_BASE(SP_BASE), .SLOT_GAP(SLOT_GAP)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit_ok), .wr_idx(save_idx), .wr_data(sp_after),
    .rd_idx(load_idx), .rd_data(new_sp), .bank_flat(sp_bank_o)
  );

  always_comb begin
    loaded    = tmp_psl_q;
    loaded.tp = tmp_psl_q.tp | live_q.tp;
  end

  assign busy          = (st_q != ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ_PC) || (st_q == ST_REQ_PSL);
  assign mem_req_addr  = base_sp_q + ((st_q == ST_REQ_PSL) ? WORD_W'(STEP) : '0);
  assign pc_o  = pc_q;
  assign psl_o = live_q;
  assign sp_o  = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      live_q     <= psl_t'(RESET_PSL);
      tmp_psl_q  <= '0;
      pc_q       <= '0;
      sp_q       <= RESET_SP;
      base_sp_q  <= '0;
      tmp_pc_q   <= '0;
      done       <= 1'b0;
      rsvd_fault <= 1'b0;
      stk_fault  <= 1'b0;
    end else begin
      done       <= 1'b0;
      rsvd_fault <= 1'b0;
      stk_fault  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (init_en) begin
            live_q <= psl_t'(init_psl);
            sp_q   <= init_sp;
          end else if (start) begin
            base_sp_q <= sp_q;
            st_q      <= ST_REQ_PC;
          end
        end
        ST_REQ_PC:  if (mem_req_ready) st_q <= ST_WAIT_PC;
        ST_REQ_PSL: if (mem_req_ready) st_q <= ST_WAIT_PSL;
        ST_WAIT_PC: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              done      <= 1'b1;
              stk_fault <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              tmp_pc_q <= mem_rsp_data;
              st_q     <= ST_REQ_PSL;
            end
          end
        end
        ST_WAIT_PSL: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              done      <= 1'b1;
              stk_fault <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              tmp_psl_q <= psl_t'(mem_rsp_data);
              st_q      <= ST_COMMIT;
            end
          end
        end
        ST_COMMIT: begin
          done       <= 1'b1;
          rsvd_fault <= illegal;
          if (!illegal) begin
            pc_q   <= tmp_pc_q;
            live_q <= loaded;
            sp_q   <= new_sp;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfe_seq_chk.sv
module rfe_seq_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         init_en,
  input logic         mem_req_valid,
  input logic         mem_req_ready,
  input logic [31:0]  mem_req_addr,
  input logic         done,
  input logic         rsvd_fault,
  input logic         stk_fault,
  input logic [31:0]  pc_o,
  input logic [31:0]  psl_o,
  input logic [31:0]  sp_o,
  input logic [159:0] sp_bank_o
);
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_rsvd_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_fault |-> $stable(pc_o) && $stable(psl_o) && $stable(sp_o) && $stable(sp_bank_o));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsvd_fault || stk_fault) |-> done && $onehot0({rsvd_fault, stk_fault}));

  assert_stk_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_fault |-> $stable(pc_o) && $stable(psl_o) && $stable(sp_o) && $stable(sp_bank_o));

  assert_psl_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !$past(init_en) |-> $stable(psl_o) && $stable(pc_o));
endmodule

bind rfe_seq rfe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_en(init_en),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .rsvd_fault(rsvd_fault),
  .stk_fault(stk_fault), .pc_o(pc_o), .psl_o(psl_o), .sp_o(sp_o),
  .sp_bank_o(sp_bank_o)
);

// File: tb/sim_rfe_seq.sv
`timescale 1ns/1ps
module sim_rfe_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init_en = 1'b0;
  logic [31:0]  init_psl = '0;
  logic [31:0]  init_sp = '0;
  logic         start = 1'b0;
  logic         busy;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [31:0]  mem_rsp_data = '0;
  logic         mem_rsp_err = 1'b0;
  logic         done, rsvd_fault, stk_fault;
  logic [31:0]  pc_o, psl_o, sp_o;
  logic [159:0] sp_bank_o;

  rfe_seq u0 (.*);

  int nchk = 0, nfail = 0;
  logic [31:0] exp_bank [5];
  logic [31:0] exp_pc = '0;
  logic [31:0] exp_sp0 = '0, word_pc = '0, word_psl = '0;
  int err_at = 0, req_n = 0, pop_n = 0, cyc = 0;
  bit pend = 0;

  initial forever #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model: ready stalls one cycle in three; response one cycle after acceptance.
  initial forever begin
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = (pop_n == 0) ? word_pc : word_psl;
      mem_rsp_err   = (err_at == pop_n + 1);
      pop_n++;
      pend = 0;
    end
    mem_req_ready = (cyc % 3) != 2;
    cyc++;
    if (mem_req_valid && mem_req_ready) begin
      chk(mem_req_addr == exp_sp0 + 32'(4 * req_n), "R1", "pop address",
          mem_req_addr, exp_sp0 + 32'(4 * req_n));
      req_n++;
      pend = 1;
    end
  end

  function automatic string fault_tag(logic [31:0] o, logic [31:0] w);
    if (w[25:24] < o[25:24] || w[23:22] < o[25:24] || w[20:16] > o[20:16] ||
        w[29:28] != 0 || w[21] || w[15:8] != 0) return "R2";
    if (w[26] && (!o[26] || w[25:24] != 0 || w[20:16] == 0)) return "R3";
    if (w[20:16] != 0 && w[25:24] != 0) return "R4";
    if (w[31] && (w[27] || w[26] || w[7] || w[6] || w[5] || w[25:24] != 3)) return "R5";
    return "";
  endfunction

  task automatic check_bank(input string req);
    for (int i = 0; i < 5; i++)
      chk(sp_bank_o[i*32 +: 32] == exp_bank[i], req, $sformatf("bank slot %0d", i),
          sp_bank_o[i*32 +: 32], exp_bank[i]);
  endtask

  task automatic run_one(input logic [31:0] old, input logic [31:0] w,
                         input logic [31:0] sp0, input logic [31:0] pcw, input int e);
    string tag;
    int wait_n;
    logic [31:0] exp_psl;
    int sv, ld;
    @(negedge clk);
    init_en = 1'b1; init_psl = old; init_sp = sp0;
    @(negedge clk);
    init_en = 1'b0;
    exp_sp0 = sp0; word_pc = pcw; word_psl = w; err_at = e;
    req_n = 0; pop_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done, "R6", "done seen", 32'(done), 32'd1);
    tag = fault_tag(old, w);
    if (e != 0) begin
      chk(stk_fault && !rsvd_fault, "R11", "access fault flags",
          {30'd0, stk_fault, rsvd_fault}, 32'd2);
      chk(sp_o == sp0, "R11", "sp restored", sp_o, sp0);
      chk(psl_o == old, "R11", "psl kept", psl_o, old);
      chk(pc_o == exp_pc, "R11", "pc kept", pc_o, exp_pc);
      chk(req_n == e, "R11", "no extra pop", 32'(req_n), 32'(e));
      check_bank("R11");
    end else if (tag != "") begin
      chk(rsvd_fault && !stk_fault, tag, "reserved fault expected",
          {30'd0, stk_fault, rsvd_fault}, 32'd1);
      chk(sp_o == sp0 && psl_o == old && pc_o == exp_pc, "R6", "state frozen",
          psl_o, old);
      check_bank("R6");
    end else begin
      chk(!rsvd_fault && !stk_fault, "R10", "no fault", 32'(rsvd_fault), 32'd0);
      exp_pc  = pcw;
      exp_psl = w | (old & 32'h4000_0000);
      sv = old[26] ? 4 : int'(old[25:24]);
      ld = w[26] ? 4 : int'(w[25:24]);
      exp_bank[sv] = sp0 + 32'd8;
      chk(pc_o == exp_pc, "R10", "pc loaded", pc_o, exp_pc);
      chk(psl_o == exp_psl, (old[30] && !w[30]) ? "R9" : "R10", "psl loaded",
          psl_o, exp_psl);
      chk(psl_o[3:0] == w[3:0], "R10", "condition codes", 32'(psl_o[3:0]), 32'(w[3:0]));
      chk(sp_o == exp_bank[ld], "R8", "new sp", sp_o, exp_bank[ld]);
      check_bank("R7");
    end
  endtask

  initial begin
    #800000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] olds [4];
    logic [4:0]  ipls [3];
    int run = 0;
    olds[0] = 32'h0405_0000; olds[1] = 32'h4003_0005;
    olds[2] = 32'h02C0_0000; olds[3] = 32'h43C0_0000;
    ipls[0] = 5'd0; ipls[1] = 5'd2; ipls[2] = 5'd5;
    for (int i = 0; i < 5; i++) exp_bank[i] = 32'h0001_0000 + 32'h1000 * 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(psl_o == 32'h041F_0000, "R12", "reset psl", psl_o, 32'h041F_0000);
    chk(pc_o == 0 && !done && !busy, "R12", "reset pc/idle", pc_o, 32'd0);
    chk(sp_o == 32'h0000_F000, "R12", "reset sp", sp_o, 32'h0000_F000);
    check_bank("R12");
    init_en = 1'b1; init_psl = 32'h02C0_0003; init_sp = 32'h0000_7770;
    @(negedge clk);
    init_en = 1'b0;
    chk(psl_o == 32'h02C0_0003 && sp_o == 32'h0000_7770, "R12", "init load",
        psl_o, 32'h02C0_0003);
    for (int o = 0; o < 4; o++)
      for (int cm = 0; cm < 2; cm++)
        for (int f = 0; f < 3; f++)
          for (int is = 0; is < 2; is++)
            for (int cu = 0; cu < 4; cu++)
              for (int pv = 0; pv < 4; pv++)
                for (int ip = 0; ip < 3; ip++)
                  for (int mz = 0; mz < 2; mz++) begin
                    logic [31:0] w;
                    w = '0;
                    w[31] = cm[0];
                    w[30] = run[0];
                    w[27] = (f == 1);
                    w[7]  = (f == 2);
                    w[26] = is[0];
                    w[25:24] = cu[1:0];
                    w[23:22] = pv[1:0];
                    w[20:16] = ipls[ip];
                    w[4:0] = 5'(run >> 1);
                    if (mz != 0) begin
                      if (run % 3 == 0) w[28] = 1'b1;
                      else if (run % 3 == 1) w[21] = 1'b1;
                      else w[9] = 1'b1;
                    end
                    run_one(olds[o], w, 32'h0000_8000 + 32'h40 * 32'(run % 16),
                            32'h1000_0000 + 32'(run * 4), 0);
                    run++;
                  end
    // Access errors on each pop, then a clean return.
    run_one(olds[0], 32'h0004_0000, 32'h0000_9000, 32'hAAAA_0000, 1);
    run_one(olds[0], 32'h0004_0000, 32'h0000_9100, 32'hAAAA_0004, 2);
    run_one(olds[1], 32'h0002_0000, 32'h0000_9200, 32'hAAAA_0008, 2);
    run_one(olds[0], 32'h0004_000F, 32'h0000_9300, 32'hAAAA_000C, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule